// File: doc/BRIEF.md
# Packed Integer SIMD Execution Unit

This block is a 64-bit packed integer execution unit with a registered output. One request carries two 64-bit operands, a 4-bit operation code and a 2-bit lane-size code. The operands are treated as 8 byte lanes, 4 word lanes or 2 doubleword lanes. Lane i occupies bits [i*W +: W], where W is the lane width. Each lane works on its own: no carry, borrow or compare result passes between lanes, and the unit sets no condition flags.

The operations are lane-wise add and subtract, each in wrap-around, signed-saturating and unsigned-saturating form. There is a word-only multiply that returns the low half, the signed high half or the unsigned high half of each 32-bit product. Equality and signed greater-than compares return all-ones or all-zeros lane masks. AND, AND-NOT, OR and XOR act on the full 64-bit width. A mask from a compare can be combined with AND, AND-NOT and OR to make a branch-free per-lane select. If a request names an opcode/size pair that the unit does not support, the result is zero and a one-cycle illegal indication is raised.

Opcode encoding: 0 add-wrap, 1 add-signed-sat, 2 add-unsigned-sat, 3 sub-wrap, 4 sub-signed-sat, 5 sub-unsigned-sat, 6 mul-low, 7 mul-high-signed, 8 mul-high-unsigned, 9 compare-equal, 10 compare-greater (signed), 11 AND, 12 AND-NOT, 13 OR, 14 XOR, 15 reserved. Lane-size encoding: 0 byte, 1 word, 2 doubleword, 3 reserved.

Top module: `simd_alu`

## Requirements
- R1: Opcodes 0 (add) and 3 (sub) compute each lane modulo 2^W for the selected lane size 0/1/2. A carry or borrow never reaches the neighbouring lane.
- R2: Opcodes 1 and 4 treat lanes as two's complement. A result above the signed maximum becomes the signed maximum (e.g. byte 0x7F). A result below the signed minimum becomes the signed minimum (e.g. byte 0x80).
- R3: Opcodes 2 and 5 treat lanes as unsigned. An add that exceeds all-ones returns all-ones. A subtract that goes below zero returns zero.
- R4: Opcode 6 with lane size 1 returns the low 16 bits of each 32-bit product of the word lanes.
- R5: Opcode 7 with lane size 1 returns bits [31:16] of the signed product of each word lane. Opcode 8 returns bits [31:16] of the unsigned product.
- R6: Opcode 9 sets a lane to all ones when the two lanes are equal, and to all zeros otherwise. Opcode 10 does the same when the lane of operand A is greater than the lane of operand B as signed two's complement.
- R7: Opcodes 11, 12, 13 and 14 return A&B, (~A)&B, A|B and A^B over all 64 bits. The lane-size code has no effect on these opcodes, including code 3.
- R8: The following requests are illegal: opcode 15; lane size 3 with opcodes 0-10; opcodes 6-8 with any lane size other than 1. For an illegal request the result is zero and `illegal` is 1 in the same cycle as `out_valid`. `illegal` is 0 for every legal request.
- R9: `result` and `out_valid` follow one clock edge after `in_valid`. Without `in_valid`, `out_valid` is 0 and `result` keeps its last value. A synchronous reset clears `result`, `out_valid` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code (see encoding) |
| lane_sz | input | 2 | Lane-size code: 0 byte, 1 word, 2 doubleword, 3 reserved |
| opnd_a | input | 64 | First operand (inverted by AND-NOT) |
| opnd_b | input | 64 | Second operand |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| result | output | 64 | Packed result |
| illegal | output | 1 | Previous request was an unsupported opcode/size pair |

## Verification
The hardest situations to reach are saturation at exactly one step past the lane limits and a sign change confined to one lane while its neighbours stay in range. Uniform random operands seldom land there. The stimulus therefore draws each lane from a small pool of edge values (0, 1, the signed minimum and maximum, all-ones) about half the time, and draws free random bits the rest of the time, across all three lane sizes. The masked-select idiom is run as a chain of four requests, where each later request uses the registered mask returned by the compare.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W  = 64;
    localparam int NUM_SZ  = 3;

    typedef enum logic [3:0] {
        OP_ADD      = 4'd0,
        OP_ADD_SS   = 4'd1,
        OP_ADD_US   = 4'd2,
        OP_SUB      = 4'd3,
        OP_SUB_SS   = 4'd4,
        OP_SUB_US   = 4'd5,
        OP_MUL_LO   = 4'd6,
        OP_MUL_HS   = 4'd7,
        OP_MUL_HU   = 4'd8,
        OP_CMP_EQ   = 4'd9,
        OP_CMP_GT   = 4'd10,
        OP_AND      = 4'd11,
        OP_ANDN     = 4'd12,
        OP_OR       = 4'd13,
        OP_XOR      = 4'd14,
        OP_RSVD     = 4'd15
    } simd_op_e;

    typedef enum logic [1:0] {
        LS_BYTE  = 2'd0,
        LS_WORD  = 2'd1,
        LS_DWORD = 2'd2,
        LS_RSVD  = 2'd3
    } lane_sz_e;

    typedef enum logic [1:0] {
        AR_WRAP = 2'd0,
        AR_SSAT = 2'd1,
        AR_USAT = 2'd2
    } arith_mode_e;

    typedef enum logic [1:0] {
        MS_LO   = 2'd0,
        MS_HI_S = 2'd1,
        MS_HI_U = 2'd2
    } mul_sel_e;

    typedef struct packed {
        logic        sub;
        arith_mode_e mode;
    } arith_ctl_t;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_MUL   = 2'd1,
        UNIT_CMP   = 2'd2,
        UNIT_LOGIC = 2'd3
    } unit_e;

    function automatic unit_e unit_of(simd_op_e op);
        case (op)
            OP_ADD, OP_ADD_SS, OP_ADD_US,
            OP_SUB, OP_SUB_SS, OP_SUB_US:   return UNIT_ARITH;
            OP_MUL_LO, OP_MUL_HS, OP_MUL_HU: return UNIT_MUL;
            OP_CMP_EQ, OP_CMP_GT:           return UNIT_CMP;
            default:                        return UNIT_LOGIC;
        endcase
    endfunction

    function automatic logic op_legal(simd_op_e op, lane_sz_e sz);
        if (op == OP_RSVD) return 1'b0;
        case (unit_of(op))
            UNIT_ARITH, UNIT_CMP: return sz != LS_RSVD;
            UNIT_MUL:             return sz == LS_WORD;
            default:              return 1'b1;
        endcase
    endfunction

    function automatic arith_ctl_t arith_ctl_of(simd_op_e op);
        arith_ctl_t c;
        c.sub = (op == OP_SUB) || (op == OP_SUB_SS) || (op == OP_SUB_US);
        case (op)
            OP_ADD_SS, OP_SUB_SS: c.mode = AR_SSAT;
            OP_ADD_US, OP_SUB_US: c.mode = AR_USAT;
            default:              c.mode = AR_WRAP;
        endcase
        return c;
    endfunction

    function automatic mul_sel_e mul_sel_of(simd_op_e op);
        case (op)
            OP_MUL_HS: return MS_HI_S;
            OP_MUL_HU: return MS_HI_U;
            default:   return MS_LO;
        endcase
    endfunction

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  arith_ctl_t   ctl,
    input  lane_sz_e     sz,
    output logic [W-1:0] y
);

    logic [NUM_SZ-1:0][W-1:0] by_size;

    for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
        localparam int LW = 8 << s;
        localparam int NL = W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] la, lb, r;
            logic [LW:0]   us, ss;
            assign la = a[l*LW +: LW];
            assign lb = b[l*LW +: LW];
            always_comb begin
                if (ctl.sub) begin
                    us = {1'b0, la} - {1'b0, lb};
                    ss = {la[LW-1], la} - {lb[LW-1], lb};
                end else begin
                    us = {1'b0, la} + {1'b0, lb};
                    ss = {la[LW-1], la} + {lb[LW-1], lb};
                end
                case (ctl.mode)
                    AR_SSAT: begin
                        if (ss[LW] != ss[LW-1])
                            r = ss[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
                        else
                            r = ss[LW-1:0];
                    end
                    AR_USAT: begin
                        if (us[LW]) r = ctl.sub ? '0 : '1;
                        else        r = us[LW-1:0];
                    end
                    default: r = us[LW-1:0];
                endcase
                // R3
                if (ctl.mode == AR_USAT && !ctl.sub)
                    usat_add_floor_chk: assert (r >= la);
                // R3
                if (ctl.mode == AR_USAT && ctl.sub)
                    usat_sub_ceiling_chk: assert (r <= la);
            end
            assign by_size[s][l*LW +: LW] = r;
        end
    end

    always_comb begin
        case (sz)
            LS_BYTE:  y = by_size[0];
            LS_WORD:  y = by_size[1];
            LS_DWORD: y = by_size[2];
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/simd_mul.sv
module simd_mul
    import simd_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  mul_sel_e     sel,
    output logic [W-1:0] y
);

    localparam int LW = 16;
    localparam int NL = W / LW;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [LW-1:0]          la, lb;
        logic signed [2*LW-1:0] ps;
        logic [2*LW-1:0]        pu;
        assign la = a[l*LW +: LW];
        assign lb = b[l*LW +: LW];
        assign ps = $signed(la) * $signed(lb);
        assign pu = {{LW{1'b0}}, la} * {{LW{1'b0}}, lb};
        always_comb begin
            case (sel)
                MS_HI_S: y[l*LW +: LW] = ps[2*LW-1:LW];
                MS_HI_U: y[l*LW +: LW] = pu[2*LW-1:LW];
                default: y[l*LW +: LW] = pu[LW-1:0];
            endcase
            // R4
            mul_lo_agree_chk: assert (ps[LW-1:0] == pu[LW-1:0]);
        end
    end

endmodule

// File: rtl/simd_cmp.sv
module simd_cmp
    import simd_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         gt_sel,
    input  lane_sz_e     sz,
    output logic [W-1:0] y
);

    logic [NUM_SZ-1:0][W-1:0] by_size;

    for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
        localparam int LW = 8 << s;
        localparam int NL = W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] la, lb;
            logic          eq, gt;
            assign la = a[l*LW +: LW];
            assign lb = b[l*LW +: LW];
            assign eq = (la == lb);
            assign gt = ($signed(la) > $signed(lb));
            assign by_size[s][l*LW +: LW] = (gt_sel ? gt : eq) ? '1 : '0;
            always_comb begin
                // R6
                cmp_exclusive_chk: assert (!(eq && gt));
            end
        end
    end

    always_comb begin
        case (sz)
            LS_BYTE:  y = by_size[0];
            LS_WORD:  y = by_size[1];
            LS_DWORD: y = by_size[2];
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [3:0]   op,
    input  logic [1:0]   lane_sz,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         illegal
);

    simd_op_e   op_e;
    lane_sz_e   sz_e;
    logic       legal;
    logic [W-1:0] add_y, mul_y, cmp_y, sel_y, nxt_y;

    assign op_e  = simd_op_e'(op);
    assign sz_e  = lane_sz_e'(lane_sz);
    assign legal = op_legal(op_e, sz_e);

    simd_addsub #(.W(W)) u_addsub (
        .a(opnd_a), .b(opnd_b), .ctl(arith_ctl_of(op_e)), .sz(sz_e), .y(add_y)
    );

    simd_mul #(.W(W)) u_mul (
        .a(opnd_a), .b(opnd_b), .sel(mul_sel_of(op_e)), .y(mul_y)
    );

    simd_cmp #(.W(W)) u_cmp (
        .a(opnd_a), .b(opnd_b), .gt_sel(op_e == OP_CMP_GT), .sz(sz_e), .y(cmp_y)
    );

    always_comb begin
        case (op_e)
            OP_AND:  sel_y = opnd_a & opnd_b;
            OP_ANDN: sel_y = ~opnd_a & opnd_b;
            OP_OR:   sel_y = opnd_a | opnd_b;
            OP_XOR:  sel_y = opnd_a ^ opnd_b;
            default: begin
                case (unit_of(op_e))
                    UNIT_ARITH: sel_y = add_y;
                    UNIT_MUL:   sel_y = mul_y;
                    UNIT_CMP:   sel_y = cmp_y;
                    default:    sel_y = '0;
                endcase
            end
        endcase
        nxt_y = legal ? sel_y : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            illegal   <= in_valid && !legal;
            if (in_valid) result <= nxt_y;
        end
    end

    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (result == '0));

    // R8
    illegal_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> out_valid);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

endmodule

// File: tb/sim_simd_alu.sv
module sim_simd_alu;
    import simd_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [1:0]  lane_sz = 2'd0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic        out_valid, illegal;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    simd_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    function automatic longint sx(longint v, int lw);
        return (v >= (longint'(1) <<< (lw - 1))) ? v - (longint'(1) <<< lw) : v;
    endfunction

    function automatic bit ref_bad(logic [3:0] o, logic [1:0] s);
        if (o == 4'd15) return 1'b1;
        if (o <= 4'd5 || o == 4'd9 || o == 4'd10) return s == 2'd3;
        if (o >= 4'd6 && o <= 4'd8) return s != 2'd1;
        return 1'b0;
    endfunction

    function automatic logic [63:0] ref_res(logic [3:0] o, logic [1:0] s,
                                            logic [63:0] a, logic [63:0] b);
        logic [63:0] acc = '0;
        int lw, nl;
        longint mask, smax, smin;
        if (ref_bad(o, s)) return '0;
        case (o)
            4'd11: return a & b;
            4'd12: return ~a & b;
            4'd13: return a | b;
            4'd14: return a ^ b;
            default: ;
        endcase
        lw   = 8 << s;
        nl   = 64 / lw;
        mask = (longint'(1) <<< lw) - 1;
        smax = (longint'(1) <<< (lw - 1)) - 1;
        smin = -(longint'(1) <<< (lw - 1));
        for (int i = 0; i < nl; i++) begin
            longint ua, ub, sa, sb, r;
            ua = longint'((a >> (i * lw)) & 64'(mask));
            ub = longint'((b >> (i * lw)) & 64'(mask));
            sa = sx(ua, lw);
            sb = sx(ub, lw);
            case (o)
                4'd0: r = ua + ub;
                4'd3: r = ua - ub;
                4'd1: begin r = sa + sb; if (r > smax) r = smax; if (r < smin) r = smin; end
                4'd4: begin r = sa - sb; if (r > smax) r = smax; if (r < smin) r = smin; end
                4'd2: begin r = ua + ub; if (r > mask) r = mask; end
                4'd5: begin r = ua - ub; if (r < 0) r = 0; end
                4'd6: r = ua * ub;
                4'd7: r = (sa * sb) >>> 16;
                4'd8: r = (ua * ub) >>> 16;
                4'd9: r = (ua == ub) ? mask : 0;
                default: r = (sa > sb) ? mask : 0;
            endcase
            acc = acc | ((64'(r) & 64'(mask)) << (i * lw));
        end
        return acc;
    endfunction

    function automatic string req_of(logic [3:0] o, logic [1:0] s);
        if (ref_bad(o, s)) return "R8";
        case (o)
            4'd0, 4'd3: return "R1";
            4'd1, 4'd4: return "R2";
            4'd2, 4'd5: return "R3";
            4'd6:       return "R4";
            4'd7, 4'd8: return "R5";
            4'd9, 4'd10: return "R6";
            default:    return "R7";
        endcase
    endfunction

    task automatic check64(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check1(string tag, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // Drive one request at a falling edge, sample the registered result at the next one.
    task automatic run(logic [3:0] o, logic [1:0] s, logic [63:0] a, logic [63:0] b,
                       output logic [63:0] got);
        @(negedge clk);
        op = o; lane_sz = s; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got = result;
        check64(req_of(o, s), result, ref_res(o, s, a, b));
        check1({req_of(o, s), " illegal"}, illegal, ref_bad(o, s));
        check1("R9 out_valid", out_valid, 1'b1);
    endtask

    function automatic logic [63:0] pick_val(int lw);
        logic [63:0] v = '0;
        for (int i = 0; i < 64 / lw; i++) begin
            longint e;
            case ($urandom % 8)
                0: e = 0;
                1: e = 1;
                2: e = (longint'(1) <<< (lw - 1));
                3: e = (longint'(1) <<< (lw - 1)) - 1;
                4: e = (longint'(1) <<< lw) - 1;
                default: e = longint'({$urandom, $urandom}) & ((longint'(1) <<< lw) - 1);
            endcase
            v = v | (64'(e) << (i * lw));
        end
        return v;
    endfunction

    initial begin
        logic [63:0] g, mask, t1, t2, spr, bg, clr, exp;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        check64("R9 reset result", result, '0);
        check1("R9 reset out_valid", out_valid, 1'b0);
        check1("R9 reset illegal", illegal, 1'b0);
        rst = 1'b0;

        // R1 byte wrap, no carry into neighbour
        run(4'd0, 2'd0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, g);
        check64("R1 byte wrap", g, 64'h0);
        run(4'd3, 2'd1, 64'h0001_0000_0000_0000, 64'h0000_0000_0000_0001, g);
        check64("R1 word borrow", g, 64'h0001_0000_0000_FFFF);
        // R2 signed saturation edges
        run(4'd1, 2'd0, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, g);
        check64("R2 byte max", g, 64'h7F7F_7F7F_7F7F_7F7F);
        run(4'd4, 2'd2, 64'h8000_0000_0000_0005, 64'h0000_0001_0000_0003, g);
        check64("R2 dword min", g, 64'h8000_0000_0000_0002);
        // R3 unsigned saturation
        run(4'd2, 2'd1, 64'hFFFF_0001_8000_0000, 64'h0001_0001_8000_0000, g);
        check64("R3 word sat add", g, 64'hFFFF_0002_FFFF_0000);
        run(4'd5, 2'd0, 64'h0005_0000_0000_0000, 64'h0006_0000_0000_0000, g);
        check64("R3 byte floor", g, 64'h0);
        // R4 / R5 multiply
        run(4'd6, 2'd1, 64'h0002_FFFF_0100_0003, 64'h0003_FFFF_0100_0005, g);
        run(4'd7, 2'd1, 64'hFFFF_0000_0000_0000, 64'h0001_0000_0000_0000, g);
        check64("R5 signed high", g, 64'hFFFF_0000_0000_0000);
        run(4'd8, 2'd1, 64'hFFFF_0000_0000_0000, 64'hFFFF_0000_0000_0000, g);
        check64("R5 unsigned high", g, 64'hFFFE_0000_0000_0000);
        // R6 signed compare
        run(4'd10, 2'd0, 64'h0000_0000_0000_0180, 64'h0000_0000_0000_8001, g);
        check64("R6 signed gt", g, 64'h0000_0000_0000_FF00);
        // R7 lane size ignored for logic ops, including code 3
        run(4'd12, 2'd3, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFFFF_0000_FFFF_0000, g);
        check64("R7 andnot", g, 64'h0F0F_0000_0F0F_0000);
        // R8 illegal pairs
        run(4'd6, 2'd0, 64'h1234, 64'h5678, g);
        run(4'd15, 2'd1, 64'h1234, 64'h5678, g);
        run(4'd0, 2'd3, 64'h1234, 64'h5678, g);
        @(negedge clk);
        check1("R8 illegal one cycle", illegal, 1'b0);
        // R9 hold when idle
        run(4'd13, 2'd0, 64'hAAAA, 64'h5555, g);
        @(negedge clk);
        opnd_a = '1; op = 4'd14;
        @(negedge clk);
        check64("R9 hold", result, 64'hFFFF);
        check1("R9 idle out_valid", out_valid, 1'b0);

        // R6 R7 masked select chain (word lanes)
        for (int k = 0; k < 20; k++) begin
            spr = pick_val(16);
            bg  = {$urandom, $urandom};
            clr = spr;
            clr[(k % 4) * 16 +: 16] = clr[(k % 4) * 16 +: 16] ^ 16'h0101;
            if (k % 3 == 0) clr = spr;
            run(4'd9, 2'd1, spr, clr, mask);
            run(4'd11, 2'd1, mask, bg, t1);
            run(4'd12, 2'd1, mask, spr, t2);
            run(4'd13, 2'd1, t1, t2, g);
            for (int i = 0; i < 4; i++)
                exp[i*16 +: 16] = (spr[i*16 +: 16] == clr[i*16 +: 16]) ? bg[i*16 +: 16]
                                                                        : spr[i*16 +: 16];
            check64("R6 R7 masked select", g, exp);
        end

        // Random mix over all opcodes and sizes
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] o;
            logic [1:0] s;
            o = 4'($urandom % 16);
            s = 4'($urandom % 16) < 4'd14 ? 2'($urandom % 3) : 2'd3;
            if (o >= 4'd6 && o <= 4'd8 && ($urandom % 8) != 0) s = 2'd1;
            if ($urandom % 2)
                run(o, s, pick_val(8 << ((s == 2'd3) ? 0 : s)), pick_val(8 << ((s == 2'd3) ? 0 : s)), g);
            else
                run(o, s, {$urandom, $urandom}, {$urandom, $urandom}, g);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule